// File: doc/BRIEF.md
# Vectored Interrupt Controller with Read-Acknowledge

This block gathers interrupt requests from a set of on-chip peripheral sources and presents one request line to the processor. Each source has a programmable 3-bit priority level and a trigger mode. A source can be edge-triggered, latching a rising edge until it is serviced, or level-triggered, following its input. A sequencer repeatedly runs a priority resolution pass of fixed length. When a pass finds a pending source whose level is below the current mask, the block latches the low 16 bits of that source's handler-table address and raises its request line.

The handler software first reads the mask register and then reads the vector register as a halfword, with processor interrupts disabled. That read is the acknowledge and has four effects. The mask takes the accepted source's level. An edge-type request is cleared, while a level-type request is left alone. The request line drops. A new resolution pass starts. Handler-table entries are 4 bytes apart from byte address 0x0094, so source k yields 0x0094 + 4k, and 31 sources fill the table up to 0x010F.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a synchronous reset, irq_out is low, the mask (address 1, bits 2:0) reads 7, the mode word (address 2) reads 0, the pending word (address 3) reads 0, and every level register (address 8+k) reads 7.
- R2: Resolution passes last RES_CYCLES clocks. After an acknowledge, irq_out stays low for the first RES_CYCLES-1 cycles and can rise no earlier than the RES_CYCLES-th clock edge.
- R3: A source is eligible only when it is pending and its level is strictly below the mask. The lowest level wins, and among equal levels the lower source index wins.
- R4: On acceptance the vector register holds 0x0094 + 4*index. A halfword read (bus_half=1) of address 0 returns it in bits 15:0, with bits 31:16 zero.
- R5: An acknowledge loads the mask with the accepted source's level.
- R6: An acknowledge clears the accepted source's pending bit when its mode bit is 0 (edge). When the mode bit is 1 (level), the pending bit is left set while the input stays high.
- R7: An acknowledge drops irq_out at the next edge. With no acknowledge, irq_out stays high once raised.
- R8: A halfword read of address 0 while cpu_ie=1 returns the latched vector and changes neither irq_out nor the mask nor the pending bits.
- R9: A word read (bus_half=0) of address 0 returns zero and has no side effect. Writes to address 0 are ignored.
- R10: In edge mode a pending bit is set by a 0-to-1 transition of the input, after two register stages, and holds until acknowledged. In level mode the pending bit follows the registered input. Pending bits read at address 3, bit k for source k.
- R11: Read data appears on bus_rdata one clock after the cycle with bus_rd high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NSRC | Per-source request inputs |
| cpu_ie | input | 1 | Processor interrupt-enable status; 1 suppresses acknowledge |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_half | input | 1 | 1 = halfword access, 0 = word access |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The checker assumes that bus_rd and bus_wr are never high in the same cycle. It also assumes that an acknowledge and a mask write never collide, and that RES_CYCLES stays below its saturating gap counter. The stimulus issues exactly one bus operation per task call, so these conditions always hold. Request inputs change only on the falling clock edge, so the edge detector sees clean transitions. A behavioural model tracks every cycle, including reads of the vector made before any acceptance. It skips comparing those reads, because the register's reset value is undefined.

// File: rtl/ic_pkg.sv
package ic_pkg;
  // register word addresses
  localparam int RA_VEC  = 0;
  localparam int RA_MASK = 1;
  localparam int RA_MODE = 2;
  localparam int RA_PEND = 3;
  localparam int RA_LVL0 = 8;

  typedef enum logic [0:0] {SEQ_SCAN = 1'b0, SEQ_HOLD = 1'b1} seq_st_t;
endpackage

// File: rtl/ic_reqcap.sv
module ic_reqcap #(
  parameter int NSRC = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_in,
  input  logic [NSRC-1:0] mode,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] req_q, req_p, edge_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      req_p  <= '0;
      edge_q <= '0;
    end else begin
      req_q  <= req_in;
      req_p  <= req_q;
      // a fresh edge wins over a same-cycle clear
      edge_q <= ((edge_q & ~clr) | (req_q & ~req_p)) & ~mode;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_pend
    assign pend[g] = mode[g] ? req_q[g] : edge_q[g];
  end
endmodule

// File: rtl/ic_pick.sv
module ic_pick #(
  parameter int NSRC  = 31,
  parameter int LVL_W = 3,
  parameter int IDX_W = 5
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]      mask,
  output logic                  found,
  output logic [IDX_W-1:0]      win_idx,
  output logic [LVL_W-1:0]      win_lvl
);
  // linear scan from index 0: strict compare keeps the lower index on ties
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (lvl[i*LVL_W +: LVL_W] < mask) &&
          (!found || (lvl[i*LVL_W +: LVL_W] < win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/ic_seq.sv
module ic_seq import ic_pkg::*; #(
  parameter int          LVL_W      = 3,
  parameter int          IDX_W      = 5,
  parameter int          RES_CYCLES = 4,
  parameter logic [15:0] VEC_BASE   = 16'h0094
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             found,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic             ack,
  output logic             irq,
  output logic [15:0]      vec,
  output logic [IDX_W-1:0] acc_idx,
  output logic [LVL_W-1:0] acc_lvl
);
  localparam int CNT_W = (RES_CYCLES > 1) ? $clog2(RES_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_CYCLES - 1);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take = (st == SEQ_SCAN) && (cnt == LAST) && found;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SEQ_SCAN;
      cnt <= '0;
      irq <= 1'b0;
    end else if (st == SEQ_SCAN) begin
      if (cnt == LAST) begin
        cnt <= '0;
        if (found) begin
          st  <= SEQ_HOLD;
          irq <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (ack) begin
      st  <= SEQ_SCAN;
      cnt <= '0;
      irq <= 1'b0;
    end
  end

  // vector and accepted-source record carry no reset
  always_ff @(posedge clk) begin
    if (!rst && take) begin
      vec     <= VEC_BASE + 16'({win_idx, 2'b00});
      acc_idx <= win_idx;
      acc_lvl <= win_lvl;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl import ic_pkg::*; #(
  parameter int          NSRC       = 31,
  parameter int          LVL_W      = 3,
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 32,   // must exceed NSRC
  parameter int          RES_CYCLES = 4,
  parameter logic [15:0] VEC_BASE   = 16'h0094
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_in,
  input  logic              cpu_ie,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(RA_VEC);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(RA_MASK);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(RA_MODE);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(RA_PEND);
  localparam logic [ADDR_W-1:0] A_LVL0 = ADDR_W'(RA_LVL0);

  logic [LVL_W-1:0]      mask_q;
  logic [NSRC-1:0]       mode_q;
  logic [NSRC-1:0]       pend;
  logic [NSRC-1:0]       clr;
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic                  found;
  logic [IDX_W-1:0]      win_idx, acc_idx;
  logic [LVL_W-1:0]      win_lvl, acc_lvl;
  logic [15:0]           vec;
  logic                  ack;
  logic [DATA_W-1:0]     rd_mux;
  logic [ADDR_W-1:0]     lvl_off;
  logic                  unused_wd;

  assign unused_wd = ^bus_wdata[DATA_W-1:NSRC];

  // acknowledge: halfword vector read, interrupts off, request outstanding
  assign ack = bus_rd && bus_half && !cpu_ie && irq_out && (bus_addr == A_VEC);

  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign clr[g] = ack && (acc_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (ack) begin
      mask_q <= acc_lvl;
    end else if (bus_wr && bus_addr == A_MASK) begin
      mask_q <= bus_wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (bus_wr && bus_addr == A_MODE) begin
      mode_q <= bus_wdata[NSRC-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    localparam logic [ADDR_W-1:0] A_ME = ADDR_W'(RA_LVL0 + g);
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= '1;
      end else if (bus_wr && bus_addr == A_ME) begin
        lvl_q <= bus_wdata[LVL_W-1:0];
      end
    end
    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
  end

  ic_reqcap #(.NSRC(NSRC)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_in),
    .mode   (mode_q),
    .clr    (clr),
    .pend   (pend)
  );

  ic_pick #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .pend    (pend),
    .lvl     (lvl_flat),
    .mask    (mask_q),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  ic_seq #(
    .LVL_W(LVL_W), .IDX_W(IDX_W), .RES_CYCLES(RES_CYCLES), .VEC_BASE(VEC_BASE)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl),
    .ack     (ack),
    .irq     (irq_out),
    .vec     (vec),
    .acc_idx (acc_idx),
    .acc_lvl (acc_lvl)
  );

  assign lvl_off = bus_addr - A_LVL0;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_VEC) begin
      if (bus_half) rd_mux[15:0] = vec;
    end else if (bus_addr == A_MASK) begin
      rd_mux[LVL_W-1:0] = mask_q;
    end else if (bus_addr == A_MODE) begin
      rd_mux[NSRC-1:0] = mode_q;
    end else if (bus_addr == A_PEND) begin
      rd_mux[NSRC-1:0] = pend;
    end else if (bus_addr >= A_LVL0) begin
      for (int i = 0; i < NSRC; i++) begin
        if (lvl_off == ADDR_W'(i)) rd_mux[LVL_W-1:0] = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ic_chk.sv
module ic_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int RES_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_half,
  input logic              cpu_ie,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out
);
  logic       vec_rd, ack_w;
  logic [7:0] gap;

  assign vec_rd = bus_rd && (bus_addr == ADDR_W'(ic_pkg::RA_VEC));
  assign ack_w  = vec_rd && bus_half && !cpu_ie && irq_out;

  // cycles spent with irq_out low since reset or the last acknowledge
  always_ff @(posedge clk) begin
    if (rst || irq_out) gap <= '0;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  // R7
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ack_w |=> !irq_out);

  // R7
  irq_held_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack_w) |=> irq_out);

  // R8
  ie_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && cpu_ie && irq_out) |=> irq_out);

  // R9
  word_vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !bus_half) |=> (bus_rdata == '0));

  // R4
  vec_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vec_rd |=> (bus_rdata[DATA_W-1:16] == '0));

  // R2
  pass_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> (32'(gap) >= RES_CYCLES));
endmodule

bind irq_vec_ctrl ic_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_CYCLES(RES_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_half  (bus_half),
  .cpu_ie    (cpu_ie),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  localparam int NSRC = 31;
  localparam int RES  = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] req_in = '0;
  logic            cpu_ie = 1'b0;
  logic            bus_rd = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
  logic [5:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_out;

  always #5 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rst(rst), .req_in(req_in), .cpu_ie(cpu_ie),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  int    checks = 0, fails = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference ----------------
  int   m_mask, m_cnt, m_vec, m_src, m_nm, m_best;
  int   m_lvl[NSRC];
  bit   m_mode[NSRC], m_edge[NSRC], m_rq[NSRC], m_rp[NSRC], m_p[NSRC];
  bit   m_hold = 0, m_irq = 0, m_known = 0, m_rdv = 0, m_rdok = 0, m_ack;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_mask = 7; m_cnt = 0; m_hold = 0; m_irq = 0; m_rdv = 0;
      for (int i = 0; i < NSRC; i++) begin
        m_lvl[i] = 7; m_mode[i] = 0; m_edge[i] = 0; m_rq[i] = 0; m_rp[i] = 0;
      end
    end else begin
      for (int i = 0; i < NSRC; i++) m_p[i] = m_mode[i] ? m_rq[i] : m_edge[i];
      m_ack = bus_rd && bus_addr == 0 && bus_half && !cpu_ie && m_hold;
      m_rdv = bus_rd;
      if (bus_rd) begin
        m_rdata = 0; m_rdok = 1;
        if (bus_addr == 0) begin
          if (bus_half) begin m_rdata = m_vec; m_rdok = m_known; end
        end else if (bus_addr == 1) m_rdata = m_mask;
        else if (bus_addr == 2) begin for (int i = 0; i < NSRC; i++) m_rdata[i] = m_mode[i]; end
        else if (bus_addr == 3) begin for (int i = 0; i < NSRC; i++) m_rdata[i] = m_p[i]; end
        else if (bus_addr >= 8 && bus_addr < 8 + NSRC) m_rdata = m_lvl[bus_addr - 8];
      end
      if (!m_hold) begin
        if (m_cnt == RES - 1) begin
          m_best = -1;
          for (int i = 0; i < NSRC; i++)
            if (m_p[i] && m_lvl[i] < m_mask && (m_best < 0 || m_lvl[i] < m_lvl[m_best])) m_best = i;
          if (m_best >= 0) begin
            m_vec = 148 + 4 * m_best; m_known = 1; m_src = m_best; m_nm = m_lvl[m_best];
            m_hold = 1; m_irq = 1;
          end
          m_cnt = 0;
        end else m_cnt++;
      end
      for (int i = 0; i < NSRC; i++)
        m_edge[i] = ((m_edge[i] && !(m_ack && i == m_src)) || (m_rq[i] && !m_rp[i])) && !m_mode[i];
      if (m_ack) begin m_mask = m_nm; m_hold = 0; m_irq = 0; m_cnt = 0; end
      if (bus_wr) begin
        if (bus_addr == 1) m_mask = bus_wdata[2:0];
        else if (bus_addr == 2) begin for (int i = 0; i < NSRC; i++) m_mode[i] = bus_wdata[i]; end
        else if (bus_addr >= 8 && bus_addr < 8 + NSRC) m_lvl[bus_addr - 8] = bus_wdata[2:0];
      end
      for (int i = 0; i < NSRC; i++) begin m_rp[i] = m_rq[i]; m_rq[i] = req_in[i]; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_out === m_irq, {cur_req, " irq_out"}, 32'(irq_out), 32'(m_irq));
      if (m_rdv && m_rdok) chk(bus_rdata === m_rdata, {cur_req, " R11 rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic report();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic rd(input int a, input bit h, output logic [31:0] d);
    bus_addr = 6'(a); bus_half = h; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    bus_addr = 6'(a); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 100 && !irq_out; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(17));
    tick(3);
    rst = 1'b0;

    cur_req = "R1";
    rd(1, 0, d); chk(d == 7, "R1 mask", d, 7);
    rd(2, 0, d); chk(d == 0, "R1 mode", d, 0);
    rd(3, 0, d); chk(d == 0, "R1 pend", d, 0);
    rd(13, 0, d); chk(d == 7, "R1 level", d, 7);
    chk(irq_out == 0, "R1 irq", 32'(irq_out), 0);

    wr(8 + 3, 2); wr(8 + 7, 2); wr(8 + 12, 1); wr(8 + 20, 5);

    cur_req = "R10";
    req_in[3] = 1; req_in[7] = 1; tick(1);
    req_in[3] = 0; req_in[7] = 0; tick(1);
    rd(3, 0, d); chk(d == 32'h88, "R10 edge pend", d, 32'h88);

    cur_req = "R3";
    wait_irq();
    rd(1, 0, d);
    rd(0, 1, d); chk(d == 32'h00A0, "R3 R4 tie vector", d, 32'h00A0);
    chk(irq_out == 0, "R7 irq drop", 32'(irq_out), 0);
    rd(1, 0, d); chk(d == 2, "R5 mask", d, 2);
    rd(3, 0, d); chk(d == 32'h80, "R6 edge cleared", d, 32'h80);
    tick(12); chk(irq_out == 0, "R3 equal level blocked", 32'(irq_out), 0);

    cur_req = "R8";
    wr(1, 7); wait_irq();
    cpu_ie = 1; rd(0, 1, d); cpu_ie = 0;
    chk(d == 32'h00B0, "R8 vector", d, 32'h00B0);
    chk(irq_out == 1, "R8 irq kept", 32'(irq_out), 1);
    rd(1, 0, d); chk(d == 7, "R8 mask kept", d, 7);
    cur_req = "R9";
    rd(0, 0, d); chk(d == 0, "R9 word read", d, 0);
    chk(irq_out == 1, "R9 irq kept", 32'(irq_out), 1);
    wr(0, 32'hFFFF);
    cpu_ie = 1; rd(0, 1, d); cpu_ie = 0;
    chk(d == 32'h00B0, "R9 write ignored", d, 32'h00B0);
    rd(0, 1, d); chk(d == 32'h00B0, "R4 vector", d, 32'h00B0);

    cur_req = "R6";
    wr(1, 7); wr(2, 32'h0010_0000);
    req_in[20] = 1;
    wait_irq();
    rd(1, 0, d);
    rd(0, 1, d); chk(d == 32'h00E4, "R4 level vector", d, 32'h00E4);
    cur_req = "R2";
    wr(1, 7);
    tick(RES - 2); chk(irq_out == 0, "R2 still resolving", 32'(irq_out), 0);
    tick(1);       chk(irq_out == 1, "R2 pass done", 32'(irq_out), 1);
    rd(3, 0, d); chk(d == 32'h0010_0000, "R6 level kept", d, 32'h0010_0000);
    req_in[20] = 0;
    rd(0, 1, d); chk(d == 32'h00E4, "R6 re-accepted", d, 32'h00E4);
    tick(10); chk(irq_out == 0, "R10 level released", 32'(irq_out), 0);

    cur_req = "R3 random";
    wr(2, 32'h4210_8421);
    for (int i = 0; i < NSRC; i++) wr(8 + i, (i * 3) % 8);
    wr(1, 7);
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      req_in = req_in ^ (NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom));
      if (irq_out && r < 30) begin
        cpu_ie = (r < 5); rd(0, 1, d); cpu_ie = 0;
      end else if (r < 40) wr(1, 32'($urandom_range(0, 7)));
      else if (r < 45) rd($urandom_range(0, 40), 1'($urandom_range(0, 1)), d);
      else tick(1);
    end
    tick(4);
    report();
  end
endmodule